// File: doc/BRIEF.md
# Width-Configurable Peripheral FIFO with Watermarks

This block is the data queue that sits between a serial peripheral's shift engine and its register interface. It holds 256 bytes in total. That space is carved into entries of one, two or four bytes, chosen by a width code. The entry count therefore changes with the width: 256, 128 or 64. One side pushes entries and the other pops them. For a transmit queue the register side pushes and the engine pops; for a receive queue the roles swap. A separate operation word empties the queue and starts or stops it.

Fill state is reported in three ways. A packed status word gives the level, full and empty. A programmable threshold raises a flag once the level reaches it. Three stored six-bit watermarks (start, low and high) each drive their own comparison output. A push into a full queue is dropped, and so is a pop from an empty one. Each dropped access gives a one-cycle error pulse.

Top module: `flexw_fifo`

## Requirements
- R1: After reset the queue is stopped and holds nothing: level 0, status word 10'h200, the threshold flag is low and neither error pulse is raised.
- R2: Width code 0 selects one-byte entries with 256 entries of capacity. Code 1 selects two-byte entries with 128 entries. Codes 2 and 3 select four-byte entries with 64 entries. The full flag rises when the level equals the capacity of the selected width.
- R3: Entries leave in the order they entered. Each popped value holds the low 8, 16 or 32 bits of the pushed value, and the bits above the entry width read as zero.
- R4: An operation write with bit 0 set empties the queue. Bit 1 set leaves the queue running and bit 1 clear stops it. Stopping also empties the queue. A write of only bit 1 while running keeps the contents.
- R5: While the queue is stopped, pushes and pops have no effect and raise no error pulse, and the level reads zero.
- R6: Status bit 9 is empty and bit 8 is full. Bits 7:0 carry the level modulo 256, so a full byte-wide queue shows 8'h00 with bit 8 set. Empty and full are never set together.
- R7: The control word carries the width code in bits 1:0 and an 8-bit threshold in bits 9:2. The threshold flag is high when the queue runs and its level is at least the threshold.
- R8: The watermark word holds the start count in bits 5:0, the low count in bits 15:10 and the high count in bits 25:20. The outputs are level ≥ start, level ≤ low and level ≥ high, and the word may be written at any time.
- R9: A push into a full running queue is dropped and leaves the stored data and the level as they were. It raises the overflow pulse for exactly the cycle after the edge that dropped it.
- R10: A pop from an empty running queue is dropped and raises the underflow pulse for the cycle after that edge.
- R11: A push and a pop in the same cycle leave the level unchanged. When the queue is full, the pop proceeds and the push is dropped with an overflow pulse. When the queue is empty, the push proceeds and the pop is dropped with an underflow pulse.
- R12: A control-word write while the queue runs is ignored. Width and threshold change only while stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_wr | input | 1 | Operation word write strobe |
| op_data | input | 2 | Bit 0 empties, bit 1 runs |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_data | input | 10 | Width code 1:0, threshold 9:2 |
| chk_wr | input | 1 | Watermark word write strobe |
| chk_data | input | 26 | Start 5:0, low 15:10, high 25:20 |
| push_en | input | 1 | Push one entry |
| push_data | input | 32 | Entry to push, low bytes used |
| pop_en | input | 1 | Pop the front entry |
| pop_data | output | 32 | Front entry, zero above entry width |
| level | output | 9 | Entries held |
| status | output | 10 | Empty 9, full 8, level 7:0 |
| running | output | 1 | Queue is started |
| thr_hit | output | 1 | Level has reached threshold |
| start_hit | output | 1 | Level ≥ start count |
| low_hit | output | 1 | Level ≤ low count |
| high_hit | output | 1 | Level ≥ high count |
| ovf_err | output | 1 | Push dropped on full |
| udf_err | output | 1 | Pop dropped on empty |

## Verification
The hardest state to reach is a full queue in byte mode. There the level is 256, which is wider than the status field, and the low status bits wrap to zero while the full bit is set. The stimulus pushes 256 distinct bytes with junk in the upper lanes and checks the wrapped status. It then drains the queue and compares every byte, which also exercises the wrap of the byte pointers. The two collision cases are reached on purpose: simultaneous push and pop on a full four-byte queue, and the same on an empty queue.

// File: rtl/flexw_fifo_pkg.sv
package flexw_fifo_pkg;

   typedef enum logic [1:0] {
      EW_BYTE = 2'd0,
      EW_HALF = 2'd1,
      EW_WORD = 2'd2,
      EW_ALT  = 2'd3
   } ent_w_e;

   localparam int OP_CLR_BIT = 0;
   localparam int OP_RUN_BIT = 1;
   localparam int CHK_LOW_POS  = 10;
   localparam int CHK_HIGH_POS = 20;

   function automatic logic [2:0] bytes_per(input logic [1:0] code);
      case (ent_w_e'(code))
         EW_BYTE: return 3'd1;
         EW_HALF: return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

   function automatic logic [1:0] shift_of(input logic [1:0] code);
      case (ent_w_e'(code))
         EW_BYTE: return 2'd0;
         EW_HALF: return 2'd1;
         default: return 2'd2;
      endcase
   endfunction

endpackage

// File: rtl/flexw_fifo_ctrl.sv
module flexw_fifo_ctrl
   import flexw_fifo_pkg::*;
#(
   parameter int CAP_BYTES = 256,
   parameter int PTR_W     = $clog2(CAP_BYTES),
   parameter int LVL_W     = PTR_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_wr,
   input  logic [1:0]       op_data,
   input  logic [1:0]       wsel,
   input  logic             push_en,
   input  logic             pop_en,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] rd_ptr,
   output logic [LVL_W-1:0] level,
   output logic             running,
   output logic             full,
   output logic             empty,
   output logic             push_ok,
   output logic             pop_ok,
   output logic             ovf,
   output logic             udf
);

   localparam logic [LVL_W-1:0] CAP_L = LVL_W'(CAP_BYTES);

   logic [LVL_W-1:0] cap_ent;
   logic [PTR_W-1:0] step;
   logic             clear_now;

   assign cap_ent   = CAP_L >> shift_of(wsel);
   assign step      = PTR_W'(bytes_per(wsel));
   assign full      = running && (level == cap_ent);
   assign empty     = (level == '0);
   assign push_ok   = running && !op_wr && push_en && !full;
   assign pop_ok    = running && !op_wr && pop_en && !empty;
   assign clear_now = op_data[OP_CLR_BIT] || !op_data[OP_RUN_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running <= 1'b0;
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         level   <= '0;
         ovf     <= 1'b0;
         udf     <= 1'b0;
      end else if (op_wr) begin
         running <= op_data[OP_RUN_BIT];
         ovf     <= 1'b0;
         udf     <= 1'b0;
         if (clear_now) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
         end
      end else begin
         ovf <= running && push_en && full;
         udf <= running && pop_en && empty;
         if (push_ok) wr_ptr <= wr_ptr + step;
         if (pop_ok)  rd_ptr <= rd_ptr + step;
         case ({push_ok, pop_ok})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

endmodule

// File: rtl/flexw_fifo_store.sv
module flexw_fifo_store
   import flexw_fifo_pkg::*;
#(
   parameter int CAP_BYTES = 256,
   parameter int LANES     = 4,
   parameter int PTR_W     = $clog2(CAP_BYTES)
) (
   input  logic               clk,
   input  logic [1:0]         wsel,
   input  logic               push_ok,
   input  logic [PTR_W-1:0]   wr_ptr,
   input  logic [PTR_W-1:0]   rd_ptr,
   input  logic [8*LANES-1:0] push_data,
   output logic [8*LANES-1:0] pop_data
);

   logic [7:0] mem [CAP_BYTES];
   logic [2:0] nb;

   assign nb = bytes_per(wsel);

   always_ff @(posedge clk) begin
      for (int l = 0; l < LANES; l++) begin
         if (push_ok && (3'(l) < nb))
            mem[wr_ptr + PTR_W'(l)] <= push_data[8*l +: 8];
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign pop_data[8*g +: 8] = (3'(g) < nb) ? mem[rd_ptr + PTR_W'(g)] : 8'h00;
   end

endmodule

// File: rtl/flexw_fifo_watch.sv
module flexw_fifo_watch
   import flexw_fifo_pkg::*;
#(
   parameter int LVL_W = 9,
   parameter int THR_W = 8,
   parameter int CHK_W = 6,
   parameter int CTL_W = 2 + THR_W,
   parameter int CHK_DW = CHK_HIGH_POS + CHK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [CTL_W-1:0]  ctl_data,
   input  logic              chk_wr,
   input  logic [CHK_DW-1:0] chk_data,
   input  logic              running,
   input  logic [LVL_W-1:0]  level,
   output logic [1:0]        wsel,
   output logic              thr_hit,
   output logic              start_hit,
   output logic              low_hit,
   output logic              high_hit
);

   logic [THR_W-1:0] thr_q;
   logic [CHK_W-1:0] start_q, low_q, high_q;
   logic             chk_unused;

   assign chk_unused = ^{chk_data[CHK_LOW_POS-1:CHK_W], chk_data[CHK_HIGH_POS-1:CHK_LOW_POS+CHK_W]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wsel    <= 2'd0;
         thr_q   <= '0;
         start_q <= '0;
         low_q   <= '0;
         high_q  <= '0;
      end else begin
         if (ctl_wr && !running) begin
            wsel  <= ctl_data[1:0];
            thr_q <= ctl_data[2 +: THR_W];
         end
         if (chk_wr) begin
            start_q <= chk_data[0 +: CHK_W];
            low_q   <= chk_data[CHK_LOW_POS +: CHK_W];
            high_q  <= chk_data[CHK_HIGH_POS +: CHK_W];
         end
      end
   end

   assign thr_hit   = running && (level >= LVL_W'(thr_q));
   assign start_hit = level >= LVL_W'(start_q);
   assign low_hit   = level <= LVL_W'(low_q);
   assign high_hit  = level >= LVL_W'(high_q);

endmodule

// File: rtl/flexw_fifo.sv
module flexw_fifo
   import flexw_fifo_pkg::*;
#(
   parameter int CAP_BYTES = 256,
   parameter int LANES     = 4,
   parameter int THR_W     = 8,
   parameter int CHK_W     = 6,
   parameter int PTR_W     = $clog2(CAP_BYTES),
   parameter int LVL_W     = PTR_W + 1,
   parameter int STAT_W    = LVL_W + 1,
   parameter int CTL_W     = 2 + THR_W,
   parameter int CHK_DW    = CHK_HIGH_POS + CHK_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               op_wr,
   input  logic [1:0]         op_data,
   input  logic               ctl_wr,
   input  logic [CTL_W-1:0]   ctl_data,
   input  logic               chk_wr,
   input  logic [CHK_DW-1:0]  chk_data,
   input  logic               push_en,
   input  logic [8*LANES-1:0] push_data,
   input  logic               pop_en,
   output logic [8*LANES-1:0] pop_data,
   output logic [LVL_W-1:0]   level,
   output logic [STAT_W-1:0]  status,
   output logic               running,
   output logic               thr_hit,
   output logic               start_hit,
   output logic               low_hit,
   output logic               high_hit,
   output logic               ovf_err,
   output logic               udf_err
);

   if (LANES != 4) begin : g_bad_lanes
      $error("flexw_fifo: LANES must be 4 to match the widest entry code");
   end
   if ((1 << PTR_W) != CAP_BYTES || CAP_BYTES < 4 * LANES) begin : g_bad_cap
      $error("flexw_fifo: CAP_BYTES must be a power of two of at least 16");
   end
   if (CHK_W < 1 || CHK_W > 9) begin : g_bad_chk
      $error("flexw_fifo: CHK_W must lie in 1..9");
   end

   logic [1:0]       wsel;
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic             full, empty, push_ok, pop_ok;

   flexw_fifo_ctrl #(.CAP_BYTES(CAP_BYTES), .PTR_W(PTR_W), .LVL_W(LVL_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .op_wr   (op_wr),
      .op_data (op_data),
      .wsel    (wsel),
      .push_en (push_en),
      .pop_en  (pop_en),
      .wr_ptr  (wr_ptr),
      .rd_ptr  (rd_ptr),
      .level   (level),
      .running (running),
      .full    (full),
      .empty   (empty),
      .push_ok (push_ok),
      .pop_ok  (pop_ok),
      .ovf     (ovf_err),
      .udf     (udf_err)
   );

   flexw_fifo_store #(.CAP_BYTES(CAP_BYTES), .LANES(LANES), .PTR_W(PTR_W)) u_store (
      .clk       (clk),
      .wsel      (wsel),
      .push_ok   (push_ok),
      .wr_ptr    (wr_ptr),
      .rd_ptr    (rd_ptr),
      .push_data (push_data),
      .pop_data  (pop_data)
   );

   flexw_fifo_watch #(.LVL_W(LVL_W), .THR_W(THR_W), .CHK_W(CHK_W),
                      .CTL_W(CTL_W), .CHK_DW(CHK_DW)) u_watch (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr    (ctl_wr),
      .ctl_data  (ctl_data),
      .chk_wr    (chk_wr),
      .chk_data  (chk_data),
      .running   (running),
      .level     (level),
      .wsel      (wsel),
      .thr_hit   (thr_hit),
      .start_hit (start_hit),
      .low_hit   (low_hit),
      .high_hit  (high_hit)
   );

   assign status = {empty, full, level[LVL_W-2:0]};

endmodule

// File: rtl/flexw_fifo_chk.sv
module flexw_fifo_chk #(
   parameter int CAP_BYTES = 256,
   parameter int LVL_W     = $clog2(CAP_BYTES) + 1,
   parameter int STAT_W    = LVL_W + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_wr,
   input logic              push_en,
   input logic              pop_en,
   input logic [LVL_W-1:0]  level,
   input logic [STAT_W-1:0] status,
   input logic              running,
   input logic              thr_hit,
   input logic              ovf_err,
   input logic              udf_err
);

   logic st_empty, st_full;
   assign st_empty = status[STAT_W-1];
   assign st_full  = status[STAT_W-2];

   AST_EMPTY_FULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(st_empty && st_full)); // R6
   AST_STOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (level == '0 && st_empty)); // R5
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_W'(CAP_BYTES)); // R2
   AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_err |-> $past(running && push_en && !op_wr && st_full)); // R9
   AST_UDF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      udf_err |-> $past(running && pop_en && !op_wr && st_empty)); // R10
   AST_DROP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !op_wr && push_en && st_full && !pop_en) |=> level == $past(level)); // R9
   AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !op_wr) |=> (32'(level) <= 32'($past(level)) + 1 &&
                               32'(level) + 1 >= 32'($past(level)))); // R11
   AST_THR_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      thr_hit |-> running); // R7

endmodule

bind flexw_fifo flexw_fifo_chk #(.CAP_BYTES(CAP_BYTES), .LVL_W(LVL_W), .STAT_W(STAT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .op_wr   (op_wr),
   .push_en (push_en),
   .pop_en  (pop_en),
   .level   (level),
   .status  (status),
   .running (running),
   .thr_hit (thr_hit),
   .ovf_err (ovf_err),
   .udf_err (udf_err)
);

// File: tb/flexw_fifo_test.sv
module flexw_fifo_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_wr = 1'b0;
   logic [1:0]  op_data = '0;
   logic        ctl_wr = 1'b0;
   logic [9:0]  ctl_data = '0;
   logic        chk_wr = 1'b0;
   logic [25:0] chk_data = '0;
   logic        push_en = 1'b0;
   logic [31:0] push_data = '0;
   logic        pop_en = 1'b0;
   logic [31:0] pop_data;
   logic [8:0]  level;
   logic [9:0]  status;
   logic        running, thr_hit, start_hit, low_hit, high_hit, ovf_err, udf_err;

   int n_chk = 0;
   int n_err = 0;

   always #4 clk = ~clk;

   flexw_fifo uut (
      .clk(clk), .rst_n(rst_n), .op_wr(op_wr), .op_data(op_data),
      .ctl_wr(ctl_wr), .ctl_data(ctl_data), .chk_wr(chk_wr), .chk_data(chk_data),
      .push_en(push_en), .push_data(push_data), .pop_en(pop_en), .pop_data(pop_data),
      .level(level), .status(status), .running(running), .thr_hit(thr_hit),
      .start_hit(start_hit), .low_hit(low_hit), .high_hit(high_hit),
      .ovf_err(ovf_err), .udf_err(udf_err)
   );

   task automatic expect_eq(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic do_op(input logic [1:0] v);
      op_wr = 1'b1; op_data = v; tick(); op_wr = 1'b0;
   endtask

   task automatic do_ctl(input logic [1:0] w, input logic [7:0] thr);
      ctl_wr = 1'b1; ctl_data = {thr, w}; tick(); ctl_wr = 1'b0;
   endtask

   task automatic do_lchk(input logic [5:0] s, input logic [5:0] lo, input logic [5:0] hi);
      chk_data = '1;
      chk_data[5:0] = s; chk_data[15:10] = lo; chk_data[25:20] = hi;
      chk_wr = 1'b1; tick(); chk_wr = 1'b0;
   endtask

   task automatic push(input logic [31:0] d);
      push_en = 1'b1; push_data = d; tick(); push_en = 1'b0;
   endtask

   task automatic pop_exp(input string tag, input logic [31:0] exp);
      expect_eq(tag, pop_data, exp);
      pop_en = 1'b1; tick(); pop_en = 1'b0;
   endtask

   task automatic both(input logic [31:0] d);
      push_en = 1'b1; pop_en = 1'b1; push_data = d; tick();
      push_en = 1'b0; pop_en = 1'b0;
   endtask

   task automatic t_reset();
      expect_eq("R1 running", running, 0);
      expect_eq("R1 level", level, 0);
      expect_eq("R1 status", status, 10'h200);
      expect_eq("R1 thr", thr_hit, 0);
      expect_eq("R1 errs", {ovf_err, udf_err}, 0);
   endtask

   task automatic t_byte();
      int bad = 0;
      do_ctl(2'd0, 8'd0);
      do_op(2'b11);
      for (int i = 0; i < 256; i++) begin
         push(32'hFFFFFF00 | ((i * 7 + 3) & 8'hFF));
         if (i == 4) expect_eq("R6 status level 5", status, 10'h005);
      end
      expect_eq("R2 byte level full", level, 256);
      expect_eq("R6 byte full wrapped status", status, 10'h100);
      for (int i = 0; i < 256; i++) begin
         if (pop_data != ((i * 7 + 3) & 8'hFF)) bad++;
         pop_en = 1'b1; tick(); pop_en = 1'b0;
      end
      expect_eq("R3 byte order mismatches", bad, 0);
      expect_eq("R6 drained status", status, 10'h200);
   endtask

   task automatic t_half();
      do_op(2'b00);
      do_ctl(2'd1, 8'd0);
      do_op(2'b11);
      for (int i = 0; i < 128; i++) push(32'hA5A50000 | (i * 3));
      expect_eq("R2 half level full", level, 128);
      expect_eq("R2 half status", status, 10'h180);
      pop_exp("R3 half first", 32'h0000_0000);
      pop_exp("R3 half second", 32'h0000_0003);
   endtask

   task automatic t_wide();
      int bad = 0;
      do_op(2'b00);
      do_ctl(2'd2, 8'd0);
      do_op(2'b11);
      for (int i = 0; i < 64; i++) push(32'h1000_0000 + i * 32'h0101_0101);
      expect_eq("R2 word full", status[8], 1);
      expect_eq("R2 word level", level, 64);
      for (int i = 0; i < 64; i++) begin
         if (pop_data != 32'h1000_0000 + i * 32'h0101_0101) bad++;
         pop_en = 1'b1; tick(); pop_en = 1'b0;
      end
      expect_eq("R3 word order mismatches", bad, 0);
      do_op(2'b00);
      do_ctl(2'd3, 8'd0);
      do_op(2'b11);
      for (int i = 0; i < 63; i++) push(i);
      expect_eq("R2 code3 not full at 63", status[8], 0);
      push(32'h77);
      expect_eq("R2 code3 full at 64", status[8], 1);
   endtask

   task automatic t_ops();
      do_op(2'b00);
      do_ctl(2'd0, 8'd0);
      do_op(2'b11);
      push(1); push(2); push(3);
      do_op(2'b10);
      expect_eq("R4 start keeps level", level, 3);
      do_op(2'b11);
      expect_eq("R4 clear+start level", level, 0);
      expect_eq("R4 clear+start runs", running, 1);
      push(4); push(5);
      do_op(2'b01);
      expect_eq("R4 clear-only stops", running, 0);
      expect_eq("R4 clear-only level", level, 0);
      do_op(2'b10);
      push(6);
      do_op(2'b00);
      expect_eq("R4 stop empties", status, 10'h200);
   endtask

   task automatic t_stopped();
      push(32'h55);
      expect_eq("R5 push ignored level", level, 0);
      expect_eq("R5 no ovf", ovf_err, 0);
      pop_en = 1'b1; tick(); pop_en = 1'b0;
      expect_eq("R5 no udf", udf_err, 0);
      do_op(2'b10);
      expect_eq("R5 empty after start", status, 10'h200);
      push(32'hAA);
      pop_exp("R5 ignored push did not land", 32'hAA);
   endtask

   task automatic t_thresh();
      do_op(2'b00);
      do_ctl(2'd0, 8'd4);
      do_op(2'b11);
      expect_eq("R7 thr at 0", thr_hit, 0);
      push(1); push(2); push(3);
      expect_eq("R7 thr at 3", thr_hit, 0);
      do_ctl(2'd2, 8'd1);
      expect_eq("R12 running ctl write ignored", thr_hit, 0);
      push(4);
      expect_eq("R7 thr at 4", thr_hit, 1);
      pop_exp("R12 width kept at byte", 32'h1);
      expect_eq("R7 thr back at 3", thr_hit, 0);
   endtask

   task automatic t_chk();
      do_op(2'b00);
      do_lchk(6'd2, 6'd1, 6'd3);
      do_ctl(2'd0, 8'd0);
      do_op(2'b11);
      expect_eq("R8 level0 s/l/h", {start_hit, low_hit, high_hit}, 3'b010);
      push(9);
      expect_eq("R8 level1 s/l/h", {start_hit, low_hit, high_hit}, 3'b010);
      push(9);
      expect_eq("R8 level2 s/l/h", {start_hit, low_hit, high_hit}, 3'b100);
      push(9);
      expect_eq("R8 level3 s/l/h", {start_hit, low_hit, high_hit}, 3'b101);
   endtask

   task automatic t_ovf();
      do_op(2'b00);
      do_ctl(2'd2, 8'd0);
      do_op(2'b11);
      for (int i = 0; i < 64; i++) push(32'hC000_0000 + i);
      push(32'hDEAD_BEEF);
      expect_eq("R9 ovf pulse", ovf_err, 1);
      expect_eq("R9 level held", level, 64);
      tick();
      expect_eq("R9 ovf one cycle", ovf_err, 0);
      pop_exp("R9 data intact", 32'hC000_0000);
   endtask

   task automatic t_udf();
      do_op(2'b11);
      pop_en = 1'b1; tick(); pop_en = 1'b0;
      expect_eq("R10 udf pulse", udf_err, 1);
      expect_eq("R10 level 0", level, 0);
      tick();
      expect_eq("R10 udf one cycle", udf_err, 0);
   endtask

   task automatic t_simul();
      do_op(2'b11);
      push(32'h11); push(32'h22);
      both(32'h33);
      expect_eq("R11 level kept", level, 2);
      pop_exp("R11 front advanced", 32'h22);
      pop_exp("R11 new entry stored", 32'h33);
      for (int i = 0; i < 64; i++) push(i);
      both(32'h99);
      expect_eq("R11 full: pop only", level, 63);
      expect_eq("R11 full: ovf", ovf_err, 1);
      do_op(2'b11);
      both(32'h5A);
      expect_eq("R11 empty: push only", level, 1);
      expect_eq("R11 empty: udf", udf_err, 1);
      pop_exp("R11 empty: value", 32'h5A);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin : main
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_byte();
      t_half();
      t_wide();
      t_ops();
      t_stopped();
      t_thresh();
      t_chk();
      t_ovf();
      t_udf();
      t_simul();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule